// File: doc/BRIEF.md
# Cache Line Refill Stall Controller

This controller sits between a CPU pipeline and a direct-mapped cache that is backed by slower external memory. The tag lookup is done outside the block. The controller receives a hit flag for each of the code and data read buses, together with the address of each request. When a request misses, the block raises one wait signal in the same cycle. That signal freezes every pipeline stage, and it stays high until the whole line has been refilled.

During a refill the controller reads each word of the line from external memory. It starts at the highest word of the line and works down to word 0. It holds each external read for a fixed number of wait states before it captures the word into the cache. It writes the tag and sets the valid bit together with the final word. The CPU never sees the external wait states, because they are all absorbed inside the stall.

A data miss and a code miss in the same cycle are handled back to back, with the data line first. After reset, the controller clears every tag entry in sequence before it lets the pipeline run.

Top module: `refill_stall_ctrl`

## Requirements
- R1: After reset is released, `tag_we_o` is high with `tag_valid_o` low for NUM_LINES consecutive cycles. `tag_idx_o` steps 0, 1, ... NUM_LINES-1, one entry per cycle. `mem_wait_o` is high for exactly those cycles.
- R2: A request with its hit input low raises `mem_wait_o` combinationally in the same cycle. The signal stays high without a gap until the refill ends. A single miss therefore stalls for 1 + LINE_WORDS*(WAIT_STATES+1) cycles. It drops in the cycle after word 0 is stored.
- R3: The refill reads words in descending order, LINE_WORDS-1 down to 0. `ext_addr_o` carries the miss address bits [31:4], the word number in bits [3:2], and zero in bits [1:0].
- R4: `ext_rd_o` is held, with `ext_addr_o` stable, for WAIT_STATES+1 cycles per word. `cache_we_o` pulses only in the last of those cycles. In that cycle `cache_wdata_o` equals `ext_data_i` and `cache_addr_o` is {address bits [7:4], word number}.
- R5: The refill writes the tag with `tag_valid_o` high, `tag_o` = address bits [31:8] and `tag_idx_o` = address bits [7:4]. This write happens in the same cycle as the store of word 0.
- R6: If the code and data buses miss in the same cycle, the data line is refilled first. The code line follows at once, and `mem_wait_o` does not drop between the two. The stall lasts 1 + 2*LINE_WORDS*(WAIT_STATES+1) cycles.
- R7: A request that hits on either bus leaves `mem_wait_o` low and starts no external read.
- R8: A miss on the code bus alone refills the line addressed by `code_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_req_i | input | 1 | Code read request |
| code_addr_i | input | 32 | Code byte address |
| code_hit_i | input | 1 | Tag lookup hit for the code address |
| data_req_i | input | 1 | Data read request |
| data_addr_i | input | 32 | Data byte address |
| data_hit_i | input | 1 | Tag lookup hit for the data address |
| ext_data_i | input | 32 | Read data from external memory |
| mem_wait_o | output | 1 | Freezes all pipeline stages while high |
| ext_rd_o | output | 1 | External memory read strobe |
| ext_addr_o | output | 32 | External memory byte address |
| cache_we_o | output | 1 | Cache data array write strobe |
| cache_addr_o | output | 6 | Cache data word address {index, word} |
| cache_wdata_o | output | 32 | Cache data array write data |
| tag_we_o | output | 1 | Tag store write strobe |
| tag_idx_o | output | 4 | Tag store entry index |
| tag_o | output | 24 | Tag value written |
| tag_valid_o | output | 1 | Valid bit written |

## Verification
The hardest case to reach from the ports is the chained refill. Both buses must miss on different lines in the same idle cycle, so that the pending code miss is picked up exactly as word 0 of the data line is stored. The bench reaches it by presenting both requests in one cycle, on lines that reset has left invalid. Its own tag model answers the hit inputs, so both misses are real. The bench then checks that the wait signal never drops and that eight descending read segments appear, the data line first.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    PH_SWEEP = 2'd0,
    PH_IDLE  = 2'd1,
    PH_FILL  = 2'd2
  } rsc_phase_e;
endpackage

// File: rtl/rsc_sweep.sv
module rsc_sweep #(
  parameter int NUM_LINES = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             active_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == IDX_W'(NUM_LINES - 1)) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign idx_o    = cnt_q;

  assert_sweep_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && (cnt_q != IDX_W'(NUM_LINES - 1)) |=> active_q && (cnt_q == $past(cnt_q) + 1'b1));
  assert_sweep_ends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |=> !active_q);
endmodule

// File: rtl/rsc_word_seq.sv
module rsc_word_seq #(
  parameter int LINE_WORDS  = 4,
  parameter int WAIT_STATES = 2,
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int WS_W   = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] word_o,
  output logic              capture_o,
  output logic              last_o
);
  logic              busy_q;
  logic [WORD_W-1:0] word_q;
  logic [WS_W-1:0]   ws_q;

  assign capture_o = busy_q && (ws_q == WS_W'(WAIT_STATES));
  assign last_o    = capture_o && (word_q == '0);
  assign busy_o    = busy_q;
  assign word_o    = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      word_q <= '0;
      ws_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      word_q <= WORD_W'(LINE_WORDS - 1);
      ws_q   <= '0;
    end else if (capture_o) begin
      ws_q <= '0;
      if (word_q == '0) busy_q <= 1'b0;
      else word_q <= word_q - 1'b1;
    end else if (busy_q) begin
      ws_q <= ws_q + 1'b1;
    end
  end

  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o && !last_o |=> busy_o && (word_o == $past(word_o) - 1'b1));
  assert_hold_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !capture_o |=> busy_o && $stable(word_o));
  assert_start_when_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q || last_o);
endmodule

// File: rtl/rsc_miss_arb.sv
module rsc_miss_arb #(
  parameter int LINE_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              fill_done_i,
  input  logic              code_miss_i,
  input  logic              data_miss_i,
  input  logic [LINE_W-1:0] code_line_i,
  input  logic [LINE_W-1:0] data_line_i,
  output logic              start_o,
  output logic [LINE_W-1:0] start_line_o
);
  logic              pend_q;
  logic [LINE_W-1:0] pend_line_q;
  logic              fresh, chain;

  assign fresh        = idle_i && (code_miss_i || data_miss_i);
  assign chain        = fill_done_i && pend_q;
  assign start_o      = fresh || chain;
  // data wins a tie; the code line waits in pend_line_q
  assign start_line_o = chain ? pend_line_q : (data_miss_i ? data_line_i : code_line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_line_q <= '0;
    end else if (fresh && data_miss_i && code_miss_i) begin
      pend_q      <= 1'b1;
      pend_line_q <= code_line_i;
    end else if (chain) begin
      pend_q <= 1'b0;
    end
  end

  assert_pend_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(idle_i && data_miss_i && code_miss_i));
  assert_pend_only_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !idle_i);
endmodule

// File: rtl/refill_stall_ctrl.sv
module refill_stall_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int NUM_LINES   = 16,
  parameter int WAIT_STATES = 2,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int LINE_W = ADDR_W - WORD_W - BYTE_W,
  localparam int TAG_W  = LINE_W - IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    code_req_i,
  input  logic [ADDR_W-1:0]       code_addr_i,
  input  logic                    code_hit_i,
  input  logic                    data_req_i,
  input  logic [ADDR_W-1:0]       data_addr_i,
  input  logic                    data_hit_i,
  input  logic [DATA_W-1:0]       ext_data_i,
  output logic                    mem_wait_o,
  output logic                    ext_rd_o,
  output logic [ADDR_W-1:0]       ext_addr_o,
  output logic                    cache_we_o,
  output logic [IDX_W+WORD_W-1:0] cache_addr_o,
  output logic [DATA_W-1:0]       cache_wdata_o,
  output logic                    tag_we_o,
  output logic [IDX_W-1:0]        tag_idx_o,
  output logic [TAG_W-1:0]        tag_o,
  output logic                    tag_valid_o
);
  import rsc_pkg::*;

  logic              sweep_act;
  logic [IDX_W-1:0]  sweep_idx;
  logic              fill_busy, capture, last;
  logic [WORD_W-1:0] word;
  logic              start;
  logic [LINE_W-1:0] start_line, cur_line_q;
  logic              code_miss, data_miss, idle;
  rsc_phase_e        phase;
  logic              unused_low_bits;

  assign unused_low_bits = ^{code_addr_i[WORD_W+BYTE_W-1:0], data_addr_i[WORD_W+BYTE_W-1:0]};

  assign code_miss = code_req_i && !code_hit_i;
  assign data_miss = data_req_i && !data_hit_i;

  always_comb begin
    if (sweep_act)      phase = PH_SWEEP;
    else if (fill_busy) phase = PH_FILL;
    else                phase = PH_IDLE;
  end
  assign idle = (phase == PH_IDLE);

  rsc_sweep #(.NUM_LINES(NUM_LINES)) u_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_o (sweep_act),
    .idx_o    (sweep_idx)
  );

  rsc_miss_arb #(.LINE_W(LINE_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle),
    .fill_done_i  (last),
    .code_miss_i  (code_miss),
    .data_miss_i  (data_miss),
    .code_line_i  (code_addr_i[ADDR_W-1:WORD_W+BYTE_W]),
    .data_line_i  (data_addr_i[ADDR_W-1:WORD_W+BYTE_W]),
    .start_o      (start),
    .start_line_o (start_line)
  );

  rsc_word_seq #(.LINE_WORDS(LINE_WORDS), .WAIT_STATES(WAIT_STATES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .busy_o    (fill_busy),
    .word_o    (word),
    .capture_o (capture),
    .last_o    (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cur_line_q <= '0;
    else if (start) cur_line_q <= start_line;
  end

  assign mem_wait_o    = !idle || code_miss || data_miss;
  assign ext_rd_o      = fill_busy;
  assign ext_addr_o    = {cur_line_q, word, {BYTE_W{1'b0}}};
  assign cache_we_o    = capture;
  assign cache_addr_o  = {cur_line_q[IDX_W-1:0], word};
  assign cache_wdata_o = ext_data_i;
  assign tag_we_o      = sweep_act || last;
  assign tag_idx_o     = sweep_act ? sweep_idx : cur_line_q[IDX_W-1:0];
  assign tag_o         = sweep_act ? '0 : cur_line_q[LINE_W-1:IDX_W];
  assign tag_valid_o   = !sweep_act && last;

  assert_wait_when_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE) |-> mem_wait_o);
  assert_release_after_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) && ($past(phase) == PH_FILL) |-> $past(tag_we_o && tag_valid_o));
  assert_tag_with_word0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o && tag_valid_o |-> cache_we_o && (cache_addr_o[WORD_W-1:0] == '0));
  assert_sweep_invalid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SWEEP) |-> tag_we_o && !tag_valid_o && !ext_rd_o);
  assert_addr_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o && !cache_we_o |=> ext_rd_o && $stable(ext_addr_o));
endmodule

// File: tb/sim_refill_stall_ctrl.sv
module sim_refill_stall_ctrl;
  localparam int WS    = 2;
  localparam int PER_W = WS + 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        code_req_i = 1'b0, data_req_i = 1'b0;
  logic [31:0] code_addr_i = '0, data_addr_i = '0;
  logic        code_hit_i, data_hit_i;
  logic [31:0] ext_data_i;
  logic        mem_wait_o, ext_rd_o, cache_we_o, tag_we_o, tag_valid_o;
  logic [31:0] ext_addr_o, cache_wdata_o;
  logic [5:0]  cache_addr_o;
  logic [3:0]  tag_idx_o;
  logic [23:0] tag_o;

  always #2 clk_i = ~clk_i;

  refill_stall_ctrl #(.WAIT_STATES(WS)) u0 (.*);

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16]};
  endfunction
  assign ext_data_i = mem_f(ext_addr_o);

  // external tag store model
  logic [23:0] mtag [16];
  logic        mval [16];
  initial for (int i = 0; i < 16; i++) begin mtag[i] = '0; mval[i] = 1'b1; end
  always @(posedge clk_i) if (tag_we_o) begin
    mtag[tag_idx_o] <= tag_o;
    mval[tag_idx_o] <= tag_valid_o;
  end
  always_comb begin
    code_hit_i = mval[code_addr_i[7:4]] && (mtag[code_addr_i[7:4]] == code_addr_i[31:8]);
    data_hit_i = mval[data_addr_i[7:4]] && (mtag[data_addr_i[7:4]] == data_addr_i[31:8]);
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // recorded activity of one stall
  int waits, rds, segs, wrs, tws, sws, wrbad;
  logic [31:0] seg_addr [16];
  int          seg_len  [16];
  logic [5:0]  wr_addr  [16];
  logic [23:0] tw_tag [4];
  logic [3:0]  tw_idx [4];
  logic        tw_w0  [4];
  logic [3:0]  sw_idx [32];

  task automatic sample();
    if (mem_wait_o) waits++;
    if (ext_rd_o) begin
      rds++;
      if (segs == 0 || seg_addr[segs-1] != ext_addr_o) begin
        if (segs < 16) begin seg_addr[segs] = ext_addr_o; seg_len[segs] = 0; end
        segs++;
      end
      if (segs <= 16) seg_len[segs-1]++;
    end
    if (cache_we_o) begin
      if (wrs < 16) wr_addr[wrs] = cache_addr_o;
      if (cache_wdata_o !== mem_f(ext_addr_o)) wrbad++;
      wrs++;
    end
    if (tag_we_o && tag_valid_o) begin
      if (tws < 4) begin
        tw_tag[tws] = tag_o; tw_idx[tws] = tag_idx_o;
        tw_w0[tws] = cache_we_o && (cache_addr_o[1:0] == 2'd0);
      end
      tws++;
    end
    if (tag_we_o && !tag_valid_o) begin
      if (sws < 32) sw_idx[sws] = tag_idx_o;
      sws++;
    end
  endtask

  task automatic observe();
    waits = 0; rds = 0; segs = 0; wrs = 0; tws = 0; sws = 0; wrbad = 0;
    for (int c = 0; c < 200; c++) begin
      #1;
      sample();
      if (!mem_wait_o) break;
      @(negedge clk_i);
    end
  endtask

  task automatic check_line(input string rq, input int base, input logic [31:0] addr);
    for (int k = 0; k < 4; k++) begin
      check(rq, "read address", seg_addr[base+k], {addr[31:4], 2'(3 - k), 2'b00});
      check("R4", "cycles per word", seg_len[base+k], PER_W);
      check("R4", "cache address", wr_addr[base+k], {addr[7:4], 2'(3 - k)});
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    observe();
    check("R1", "sweep wait cycles", waits, 16);
    check("R1", "sweep writes", sws, 16);
    for (int i = 0; i < 16; i++) check("R1", "sweep order", sw_idx[i], i);
    check("R1", "no reads in sweep", rds, 0);
  endtask

  task automatic test_code_miss(input logic [31:0] a);
    @(negedge clk_i);
    code_addr_i = a; code_req_i = 1'b1;
    observe();
    check("R2", "stall length", waits, 1 + 4 * PER_W);
    check("R8", "segments", segs, 4);
    check("R4", "read cycles", rds, 4 * PER_W);
    check("R4", "write data mismatches", wrbad, 0);
    check_line("R3", 0, a);
    check("R5", "tag writes", tws, 1);
    check("R5", "tag value", tw_tag[0], a[31:8]);
    check("R5", "tag index", tw_idx[0], a[7:4]);
    check("R5", "tag with word 0", tw_w0[0], 1'b1);
    check("R2", "released wait", mem_wait_o, 1'b0);
    @(negedge clk_i);
    code_req_i = 1'b0;
  endtask

  task automatic test_hit(input logic [31:0] a);
    @(negedge clk_i);
    code_addr_i = a; data_addr_i = {a[31:4], 4'hC};
    code_req_i = 1'b1; data_req_i = 1'b1;
    observe();
    check("R7", "hit wait", waits, 0);
    check("R7", "hit reads", rds, 0);
    @(negedge clk_i);
    code_req_i = 1'b0; data_req_i = 1'b0;
  endtask

  task automatic test_data_miss(input logic [31:0] a);
    @(negedge clk_i);
    data_addr_i = a; data_req_i = 1'b1;
    observe();
    check("R2", "data stall length", waits, 1 + 4 * PER_W);
    check("R3", "data segments", segs, 4);
    check_line("R3", 0, a);
    check("R4", "data write mismatches", wrbad, 0);
    check("R5", "data tag value", tw_tag[0], a[31:8]);
    check("R5", "data tag with word 0", tw_w0[0], 1'b1);
    @(negedge clk_i);
    data_req_i = 1'b0;
  endtask

  task automatic test_both(input logic [31:0] da, input logic [31:0] ca);
    @(negedge clk_i);
    data_addr_i = da; code_addr_i = ca;
    data_req_i = 1'b1; code_req_i = 1'b1;
    observe();
    check("R6", "chained stall length", waits, 1 + 8 * PER_W);
    check("R6", "chained segments", segs, 8);
    check_line("R6", 0, da);
    check_line("R6", 4, ca);
    check("R6", "tag writes", tws, 2);
    check("R6", "first tag index", tw_idx[0], da[7:4]);
    check("R6", "second tag index", tw_idx[1], ca[7:4]);
    check("R6", "second tag value", tw_tag[1], ca[31:8]);
    check("R4", "chained write mismatches", wrbad, 0);
    @(negedge clk_i);
    data_req_i = 1'b0; code_req_i = 1'b0;
  endtask

  initial begin
    test_reset();
    test_code_miss(32'h0000_0034);
    test_hit(32'h0000_0034);
    test_data_miss(32'hABCD_E158);
    test_both(32'h1111_2264, 32'h3333_3388);
    test_hit(32'h3333_3380);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule